// File: doc/BRIEF.md
# Variable-Length Instruction Pre-Decoder

This block sits just behind instruction fetch in a small 32-bit register machine with sixteen general registers. It takes one 16-bit instruction word per valid strobe and, one clock later, presents that word pulled apart into its fields. The fields are the format, the opcode, the register indices, the short immediate and the branch displacement. It also presents a one-hot operation class, the memory access width, the instruction length in bytes, a flag that says a 32-bit extension word follows, and an illegal-encoding flag. The fetch unit uses the length and the extension flag to find the next instruction. Later stages use the class and the fields for steering.

The top two bits pick one of three layouts: register/register, register/immediate and conditional branch. Some register/register opcodes carry a trailing 32-bit word, which makes the instruction six bytes long. The input is a plain valid strobe with no ready. Every word presented with `in_valid` high is accepted, and the block never applies back-pressure. The output side is the same: `out_valid` pulses for one cycle for each accepted word, and the consumer must take it in that cycle.

Top module: `insn_predecoder`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a clock edge that samples `in_valid` high, and the decoded outputs for that word appear in the same cycle. While reset is active, every output is zero.
- R2: If bit 15 is 0, `out_fmt` is 1. `out_op` = bits 15:8, `out_ra` = bits 7:4, `out_rb` = bits 3:0, and `out_imm8` and `out_disp` are 0.
- R3: If bits 15:14 are 10, `out_fmt` is 2. `out_op` = bits 13:12 zero-extended, `out_ra` = bits 11:8, `out_imm8` = bits 7:0, and `out_rb` and `out_disp` are 0. Sub-operations 0 and 1 (add and subtract immediate) are class ALU. Sub-operations 2 and 3 (read and write special register) are class SYS.
- R4: If bits 15:14 are 11, `out_fmt` is 3. `out_op` = bits 13:10 zero-extended, `out_disp` = the sign-extended 10-bit offset in bits 9:0 multiplied by 2, and `out_ra`, `out_rb` and `out_imm8` are 0.
- R5: `out_len` is 6 and `out_ext` is 1 for format-1 opcodes 0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30 and 0x36–0x39. Every other word gives `out_len` 2 and `out_ext` 0.
- R6: `out_illegal` is 1 for format-1 opcodes 0x0F–0x18 and 0x3A–0x7F, and for format-3 conditions 10–15. It is never 1 for format 2. An illegal word has `out_class` 0, `out_len` 2, `out_ext` 0, `out_mwidth` 0 and `out_zext` 0.
- R7: For a legal word, `out_class` has exactly one bit set. The bits are: bit0 no-op (0x00), bit1 ALU, bit2 immediate load (0x01, 0x1B, 0x20), bit3 load, bit4 store, bit5 control flow (0x03, 0x04, 0x19, 0x1A, 0x25 and all format-3 words), and bit6 system (0x30, 0x35). Format-1 ALU opcodes are 0x02, 0x05, 0x0E, 0x26–0x2F and 0x31–0x34.
- R8: `out_mwidth` encodes 0 none, 1 byte, 2 half, 3 word. Loads are word for 0x07, 0x08, 0x0A and 0x0C, half for 0x21, 0x22 and 0x38, and byte for 0x1C, 0x1D and 0x36. Stores are word for 0x06, 0x09, 0x0B and 0x0D, half for 0x23, 0x24 and 0x39, and byte for 0x1E, 0x1F and 0x37. `out_zext` is 1 exactly for byte and half loads. All other words give width 0.
- R9: In a cycle after an edge with `in_valid` low, `out_valid` is 0 and every decoded output keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word present |
| in_word | input | 16 | Instruction word |
| out_valid | output | 1 | Decoded result present (one cycle) |
| out_fmt | output | 2 | Format 1, 2 or 3 |
| out_op | output | 8 | Opcode, sub-operation or condition |
| out_ra | output | 4 | First register index |
| out_rb | output | 4 | Second register index |
| out_imm8 | output | 8 | Unsigned short immediate |
| out_disp | output | XLEN | Branch byte displacement |
| out_class | output | 7 | One-hot operation class |
| out_len | output | 3 | Instruction length in bytes |
| out_ext | output | 1 | A 32-bit extension word follows |
| out_mwidth | output | 2 | Memory access width |
| out_zext | output | 1 | Narrow load, zero-extended |
| out_illegal | output | 1 | Unassigned encoding |

## Verification
The properties assume that `in_valid` is a clean level sampled at each rising edge, and that `in_word` is stable around that edge whenever `in_valid` is high. They place no limit on which word arrives, so any of the 65536 encodings may come in back to back. The stimulus presents every encoding once, changes the inputs only between edges, and inserts idle cycles at fixed points. Those idle cycles let the hold behaviour be seen at the ports after a wide variety of previously decoded words.

// File: rtl/insn_dec_pkg.sv
`timescale 1ns/1ps
package insn_dec_pkg;
  typedef enum logic [1:0] {
    FMT_NONE   = 2'd0,
    FMT_REGREG = 2'd1,
    FMT_REGIMM = 2'd2,
    FMT_BRANCH = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    MW_NONE = 2'd0,
    MW_BYTE = 2'd1,
    MW_HALF = 2'd2,
    MW_WORD = 2'd3
  } mwidth_e;

  localparam int CLS_W     = 7;
  localparam int CLS_NOP   = 0;
  localparam int CLS_ALU   = 1;
  localparam int CLS_LDI   = 2;
  localparam int CLS_LOAD  = 3;
  localparam int CLS_STORE = 4;
  localparam int CLS_FLOW  = 5;
  localparam int CLS_SYS   = 6;

  localparam int WORD_W       = 16;
  localparam int BR_OFF_W     = 10;
  localparam int BR_COND_LAST = 9;
endpackage

// File: rtl/insn_field_split.sv
`timescale 1ns/1ps
module insn_field_split
  import insn_dec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [WORD_W-1:0] word,
  output fmt_e              fmt,
  output logic [7:0]        op,
  output logic [3:0]        ra,
  output logic [3:0]        rb,
  output logic [7:0]        imm8,
  output logic [XLEN-1:0]   disp
);
  localparam int SEXT_W = XLEN - BR_OFF_W - 1;

  always_comb begin
    op   = '0;
    ra   = '0;
    rb   = '0;
    imm8 = '0;
    disp = '0;
    if (!word[15]) begin
      fmt = FMT_REGREG;
      op  = word[15:8];
      ra  = word[7:4];
      rb  = word[3:0];
    end else if (!word[14]) begin
      fmt  = FMT_REGIMM;
      op   = {6'd0, word[13:12]};
      ra   = word[11:8];
      imm8 = word[7:0];
    end else begin
      fmt  = FMT_BRANCH;
      op   = {4'd0, word[13:10]};
      disp = {{SEXT_W{word[BR_OFF_W-1]}}, word[BR_OFF_W-1:0], 1'b0};
    end
  end
endmodule

// File: rtl/insn_f1_table.sv
`timescale 1ns/1ps
module insn_f1_table
  import insn_dec_pkg::*;
(
  input  logic [7:0]       op,
  output logic             legal,
  output logic [CLS_W-1:0] cls,
  output logic             long_form,
  output mwidth_e          mwidth
);
  always_comb begin
    legal     = 1'b1;
    cls       = '0;
    long_form = 1'b0;
    mwidth    = MW_NONE;
    case (op)
      8'h00: cls[CLS_NOP] = 1'b1;
      8'h01, 8'h1b, 8'h20: begin cls[CLS_LDI] = 1'b1; long_form = 1'b1; end
      8'h02, 8'h05, 8'h0e, 8'h26, 8'h27, 8'h28, 8'h29, 8'h2a, 8'h2b,
      8'h2c, 8'h2d, 8'h2e, 8'h2f, 8'h31, 8'h32, 8'h33, 8'h34:
        cls[CLS_ALU] = 1'b1;
      8'h03, 8'h1a: begin cls[CLS_FLOW] = 1'b1; long_form = 1'b1; end
      8'h04, 8'h19, 8'h25: cls[CLS_FLOW] = 1'b1;
      8'h30: begin cls[CLS_SYS] = 1'b1; long_form = 1'b1; end
      8'h35: cls[CLS_SYS] = 1'b1;
      8'h07, 8'h0a: begin cls[CLS_LOAD] = 1'b1; mwidth = MW_WORD; end
      8'h08, 8'h0c: begin cls[CLS_LOAD] = 1'b1; mwidth = MW_WORD; long_form = 1'b1; end
      8'h21:        begin cls[CLS_LOAD] = 1'b1; mwidth = MW_HALF; end
      8'h22, 8'h38: begin cls[CLS_LOAD] = 1'b1; mwidth = MW_HALF; long_form = 1'b1; end
      8'h1c:        begin cls[CLS_LOAD] = 1'b1; mwidth = MW_BYTE; end
      8'h1d, 8'h36: begin cls[CLS_LOAD] = 1'b1; mwidth = MW_BYTE; long_form = 1'b1; end
      8'h06, 8'h0b: begin cls[CLS_STORE] = 1'b1; mwidth = MW_WORD; end
      8'h09, 8'h0d: begin cls[CLS_STORE] = 1'b1; mwidth = MW_WORD; long_form = 1'b1; end
      8'h23:        begin cls[CLS_STORE] = 1'b1; mwidth = MW_HALF; end
      8'h24, 8'h39: begin cls[CLS_STORE] = 1'b1; mwidth = MW_HALF; long_form = 1'b1; end
      8'h1e:        begin cls[CLS_STORE] = 1'b1; mwidth = MW_BYTE; end
      8'h1f, 8'h37: begin cls[CLS_STORE] = 1'b1; mwidth = MW_BYTE; long_form = 1'b1; end
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/insn_predecoder.sv
`timescale 1ns/1ps
module insn_predecoder
  import insn_dec_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int EXT_BYTES = 4,
  parameter int LEN_W     = $clog2(2 + EXT_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [15:0]       in_word,
  output logic              out_valid,
  output logic [1:0]        out_fmt,
  output logic [7:0]        out_op,
  output logic [3:0]        out_ra,
  output logic [3:0]        out_rb,
  output logic [7:0]        out_imm8,
  output logic [XLEN-1:0]   out_disp,
  output logic [CLS_W-1:0]  out_class,
  output logic [LEN_W-1:0]  out_len,
  output logic              out_ext,
  output logic [1:0]        out_mwidth,
  output logic              out_zext,
  output logic              out_illegal
);
  localparam int BASE_BYTES = WORD_W / 8;
  localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(BASE_BYTES);
  localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(BASE_BYTES + EXT_BYTES);

  fmt_e             fmt;
  logic [7:0]       op;
  logic [3:0]       ra, rb;
  logic [7:0]       imm8;
  logic [XLEN-1:0]  disp;
  logic             t_legal, t_long;
  logic [CLS_W-1:0] t_cls;
  mwidth_e          t_mw;

  insn_field_split #(.XLEN(XLEN)) u_split (
    .word(in_word), .fmt(fmt), .op(op), .ra(ra), .rb(rb),
    .imm8(imm8), .disp(disp)
  );

  insn_f1_table u_table (
    .op(op), .legal(t_legal), .cls(t_cls), .long_form(t_long), .mwidth(t_mw)
  );

  logic             n_legal, n_long, n_zext;
  logic [CLS_W-1:0] n_cls;
  mwidth_e          n_mw;

  always_comb begin
    n_legal = 1'b1;
    n_cls   = '0;
    n_long  = 1'b0;
    n_mw    = MW_NONE;
    case (fmt)
      FMT_REGREG: begin
        n_legal = t_legal;
        n_cls   = t_cls;
        n_long  = t_long;
        n_mw    = t_mw;
      end
      FMT_REGIMM: begin
        if (op[1]) n_cls[CLS_SYS] = 1'b1;
        else       n_cls[CLS_ALU] = 1'b1;
      end
      default: begin
        n_legal = (op <= 8'(BR_COND_LAST));
        n_cls[CLS_FLOW] = n_legal;
      end
    endcase
    if (!n_legal) begin
      n_cls  = '0;
      n_long = 1'b0;
      n_mw   = MW_NONE;
    end
    n_zext = n_cls[CLS_LOAD] && (n_mw == MW_BYTE || n_mw == MW_HALF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_fmt     <= '0;
      out_op      <= '0;
      out_ra      <= '0;
      out_rb      <= '0;
      out_imm8    <= '0;
      out_disp    <= '0;
      out_class   <= '0;
      out_len     <= '0;
      out_ext     <= 1'b0;
      out_mwidth  <= '0;
      out_zext    <= 1'b0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_fmt     <= fmt;
        out_op      <= op;
        out_ra      <= ra;
        out_rb      <= rb;
        out_imm8    <= imm8;
        out_disp    <= disp;
        out_class   <= n_cls;
        out_len     <= n_long ? LEN_LONG : LEN_SHORT;
        out_ext     <= n_long;
        out_mwidth  <= n_mw;
        out_zext    <= n_zext;
        out_illegal <= !n_legal;
      end
    end
  end
endmodule

// File: rtl/insn_predecoder_chk.sv
`timescale 1ns/1ps
module insn_predecoder_chk
  import insn_dec_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int EXT_BYTES = 4,
  parameter int LEN_W     = $clog2(2 + EXT_BYTES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [15:0]       in_word,
  input logic              out_valid,
  input logic [1:0]        out_fmt,
  input logic [7:0]        out_op,
  input logic [3:0]        out_ra,
  input logic [3:0]        out_rb,
  input logic [7:0]        out_imm8,
  input logic [XLEN-1:0]   out_disp,
  input logic [CLS_W-1:0]  out_class,
  input logic [LEN_W-1:0]  out_len,
  input logic              out_ext,
  input logic [1:0]        out_mwidth,
  input logic              out_zext,
  input logic              out_illegal
);
  localparam int LONG_LEN = 2 + EXT_BYTES;

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_op) && $stable(out_class)
                 && $stable(out_len) && $stable(out_disp) && $stable(out_illegal));

  p_fmt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_fmt == ($past(in_word[15]) ? {1'b1, $past(in_word[14])} : 2'd1));

  p_disp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_disp[0] && (out_fmt == 2'd3 || out_disp == '0));

  p_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_ext ? out_len == LEN_W'(LONG_LEN) : out_len == LEN_W'(2)));

  p_regimm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fmt == 2'd2 |-> !out_illegal);

  p_class_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_illegal ? out_class == '0 : $countones(out_class) == 1));

  p_zext_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_zext |-> out_class[CLS_LOAD] && out_mwidth != 2'd0 && out_mwidth != 2'd3);
endmodule

bind insn_predecoder insn_predecoder_chk #(.XLEN(XLEN), .EXT_BYTES(EXT_BYTES), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/insn_predecoder_test.sv
`timescale 1ns/1ps
module insn_predecoder_test;
  localparam int XLEN = 32;

  typedef struct packed {
    logic [1:0]      fmt;
    logic [7:0]      op;
    logic [3:0]      ra;
    logic [3:0]      rb;
    logic [7:0]      imm8;
    logic [XLEN-1:0] disp;
    logic [6:0]      cls;
    logic [2:0]      len;
    logic            ext;
    logic [1:0]      mw;
    logic            zx;
    logic            ill;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] in_word = '0;
  logic out_valid, out_ext, out_zext, out_illegal;
  logic [1:0] out_fmt, out_mwidth;
  logic [7:0] out_op, out_imm8;
  logic [3:0] out_ra, out_rb;
  logic [XLEN-1:0] out_disp;
  logic [6:0] out_class;
  logic [2:0] out_len;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t sb[$];

  always #4 clk = ~clk;

  insn_predecoder #(.XLEN(XLEN)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_fmt(out_fmt), .out_op(out_op), .out_ra(out_ra),
    .out_rb(out_rb), .out_imm8(out_imm8), .out_disp(out_disp), .out_class(out_class),
    .out_len(out_len), .out_ext(out_ext), .out_mwidth(out_mwidth), .out_zext(out_zext),
    .out_illegal(out_illegal)
  );

  function automatic exp_t model(input logic [15:0] w);
    exp_t e = '0;
    logic [7:0] o;
    int d;
    e.len = 3'd2;
    if (w[15] == 1'b0) begin
      o = w[15:8];
      e.fmt = 2'd1; e.op = o; e.ra = w[7:4]; e.rb = w[3:0];
      if (o == 8'h00) e.cls = 7'b0000001;
      else if (o inside {8'h02, 8'h05, 8'h0e, [8'h26:8'h2f], [8'h31:8'h34]}) e.cls = 7'b0000010;
      else if (o inside {8'h01, 8'h1b, 8'h20}) e.cls = 7'b0000100;
      else if (o inside {8'h07, 8'h08, 8'h0a, 8'h0c, 8'h21, 8'h22, 8'h38, 8'h1c, 8'h1d, 8'h36}) e.cls = 7'b0001000;
      else if (o inside {8'h06, 8'h09, 8'h0b, 8'h0d, 8'h23, 8'h24, 8'h39, 8'h1e, 8'h1f, 8'h37}) e.cls = 7'b0010000;
      else if (o inside {8'h03, 8'h04, 8'h19, 8'h1a, 8'h25}) e.cls = 7'b0100000;
      else if (o inside {8'h30, 8'h35}) e.cls = 7'b1000000;
      else e.ill = 1'b1;
      if (o inside {8'h07, 8'h08, 8'h0a, 8'h0c, 8'h06, 8'h09, 8'h0b, 8'h0d}) e.mw = 2'd3;
      if (o inside {8'h21, 8'h22, 8'h38, 8'h23, 8'h24, 8'h39}) e.mw = 2'd2;
      if (o inside {8'h1c, 8'h1d, 8'h36, 8'h1e, 8'h1f, 8'h37}) e.mw = 2'd1;
      e.zx = e.cls[3] && (e.mw == 2'd1 || e.mw == 2'd2);
      if (o inside {8'h01, 8'h03, 8'h08, 8'h09, 8'h0c, 8'h0d, 8'h1a, 8'h1b,
                    8'h1d, 8'h1f, 8'h20, 8'h22, 8'h24, 8'h30, [8'h36:8'h39]}) begin
        e.len = 3'd6; e.ext = 1'b1;
      end
    end else if (w[14] == 1'b0) begin
      e.fmt = 2'd2; e.op = {6'd0, w[13:12]}; e.ra = w[11:8]; e.imm8 = w[7:0];
      e.cls = (w[13:12] >= 2'd2) ? 7'b1000000 : 7'b0000010;
    end else begin
      e.fmt = 2'd3; e.op = {4'd0, w[13:10]};
      d = $signed(w[9:0]);
      e.disp = XLEN'(d * 2);
      if (w[13:10] > 4'd9) e.ill = 1'b1;
      else e.cls = 7'b0100000;
    end
    return e;
  endfunction

  function automatic exp_t observed();
    exp_t a;
    a.fmt = out_fmt; a.op = out_op; a.ra = out_ra; a.rb = out_rb; a.imm8 = out_imm8;
    a.disp = out_disp; a.cls = out_class; a.len = out_len; a.ext = out_ext;
    a.mw = out_mwidth; a.zx = out_zext; a.ill = out_illegal;
    return a;
  endfunction

  function automatic string req_of(input exp_t a, input exp_t e);
    if (a.fmt != e.fmt) return "R2";
    if (e.fmt == 2'd2 && (a.op != e.op || a.ra != e.ra || a.imm8 != e.imm8 || a.rb != e.rb)) return "R3";
    if (e.fmt == 2'd3 && (a.op != e.op || a.disp != e.disp)) return "R4";
    if (a.op != e.op || a.ra != e.ra || a.rb != e.rb || a.imm8 != e.imm8 || a.disp != e.disp) return "R2";
    if (a.len != e.len || a.ext != e.ext) return "R5";
    if (a.ill != e.ill) return "R6";
    if (a.cls != e.cls) return "R7";
    return "R8";
  endfunction

  // Driver: every encoding once, with an idle cycle every 4096 words.
  initial begin
    repeat (4) @(posedge clk);
    #1;
    rst_n = 1'b1;
    for (int w = 0; w < 65536; w++) begin
      @(posedge clk); #1;
      if (w != 0 && (w % 4096) == 0) begin
        in_valid = 1'b0;
        @(posedge clk); #1;
      end
      in_valid = 1'b1;
      in_word = 16'(w);
      sb.push_back(model(16'(w)));
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R1: %0d results missing, expected 0", sb.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // Reset state check (R1).
  initial begin
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_class !== '0 || out_len !== '0 || out_illegal !== 1'b0
        || out_op !== '0 || out_disp !== '0) begin
      errors++;
      $display("FAIL R1: reset outputs valid=%b class=%b len=%0d, expected all zero",
               out_valid, out_class, out_len);
    end
  end

  // Monitor / scoreboard.
  exp_t last;
  bit   have_last = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        exp_t e, a;
        a = observed();
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R1: out_valid with nothing pending, expected out_valid=0");
        end else begin
          e = sb.pop_front();
          if (a !== e) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req_of(a, e), a, e);
          end
        end
        last = a;
        have_last = 1;
      end else if (have_last) begin
        exp_t a;
        a = observed();
        checks++;
        if (a !== last) begin
          errors++;
          $display("FAIL R9: idle outputs %h expected held %h", a, last);
        end
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1: watchdog expired, actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule